// File: doc/BRIEF.md
# Upper Memory Block Address Remapper

This block is the address decoder of a memory card on a 20-bit, 1 MB address bus. The card holds a single 512 KB RAM. The RAM answers in the lowest 384 KB of the address space as conventional memory. Two optional upper memory windows, the D segment (D0000h–DFFFFh) and the E segment (E0000h–EFFFFh), can also select the card. Each window is folded into a part of the same RAM that conventional memory does not use, so no second memory chip is needed.

The upper half of the bus is split into 64 KB segment selects, and those selects are gated by bus bit 19. A selected upper window then flips the high RAM address lines that differ between its bus segment and its RAM segment. The D segment lands at RAM 60000h–6FFFFh and the E segment at RAM 70000h–7FFFFh. Conventional memory keeps identity addresses. One select term drives both the RAM chip select and the data transceiver enable. The transceiver points toward the bus only during a selected read.

Each window has a strap input. Pulled high, the strap disables its window, so a board with no jumpers fitted exposes no upper memory.

Top module: `umb_remap`

## Requirements
- R1: A bus access to 00000h–5FFFFh with a strobe asserted drives ram_cs_n and xcvr_en_n low, and ram_addr equals bus_addr[18:0].
- R2: With umb_dis[0]=0, an access to D0000h–DFFFFh selects the card, and ram_addr is 60000h plus the offset bus_addr[15:0].
- R3: With umb_dis[1]=0, an access to E0000h–EFFFFh selects the card, and ram_addr is 70000h plus the offset bus_addr[15:0].
- R4: When a window's strap is 1 (disabled), accesses to its segment leave ram_cs_n and xcvr_en_n high, and ram_addr equals bus_addr[18:0].
- R5: Accesses to 60000h–CFFFFh and F0000h–FFFFFh never select the card, whatever the straps are set to.
- R6: While memr_n and memw_n are both high, ram_cs_n and xcvr_en_n stay high.
- R7: xcvr_dir is 1 (card drives the bus) only when the card is selected and memr_n is low. Otherwise it is 0.
- R8: xcvr_en_n always equals ram_cs_n.
- R9: With both windows enabled, every selected bus address maps to a distinct RAM address. Bits [15:0] pass through unchanged, and no two selected 64 KB segments share a RAM segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_addr | input | 20 | Bus address |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| umb_dis | input | 2 | Window disable straps, 1 = disabled; bit 0 is the D segment, bit 1 is the E segment |
| ram_addr | output | 19 | Remapped RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward the bus |

## Verification
The bound checker evaluates the following on every input change:
- the chip select and transceiver enable stay equal;
- nothing is selected while both strobes are idle;
- the direction pin rises only on a selected read;
- forbidden segments and disabled windows never select the card;
- conventional addresses pass through unchanged, and offsets are preserved.

The exact RAM segment each window lands in, and the fact that no two selected segments collide, can only be shown by the bench. Its vector table and its sweep over every segment and strap combination compare the RAM address against values worked out from the memory layout.

// File: rtl/umb_remap_pkg.sv
`timescale 1ns/1ps
package umb_remap_pkg;

   // Per-window segment numbers are kept in fixed 8-bit slots.
   localparam int SEG_SLOT_W = 8;

   typedef logic [SEG_SLOT_W-1:0] seg_slot_t;

   // Strap polarity choices for the window enables.
   typedef enum logic {
      STRAP_DIS_HIGH = 1'b1,
      STRAP_DIS_LOW  = 1'b0
   } strap_pol_e;

   // Ways of forming the remapped segment field.
   typedef enum logic {
      REMAP_FLIP    = 1'b1,
      REMAP_REPLACE = 1'b0
   } remap_style_e;

endpackage

// File: rtl/umb_seg_decoder.sv
`timescale 1ns/1ps
module umb_seg_decoder #(
   parameter int SEG_BITS  = 4,
   parameter int CONV_SEGS = 6
) (
   input  logic [SEG_BITS-1:0]            seg,
   output logic [(1<<(SEG_BITS-1))-1:0]   up_sel_n,
   output logic                           conv_hit
);
   localparam int IDX_W  = SEG_BITS - 1;
   localparam int NUM_UP = 1 << IDX_W;
   localparam logic [IDX_W-1:0] CONV_LIM = IDX_W'(CONV_SEGS);

   logic            hi_half;
   logic [IDX_W-1:0] idx;

   assign hi_half = seg[SEG_BITS-1];
   assign idx     = seg[IDX_W-1:0];

   // One-hot active-low segment selects for the upper half
   for (genvar i = 0; i < NUM_UP; i++) begin : g_up
      assign up_sel_n[i] = !(hi_half && (idx == IDX_W'(i)));
   end

   // Conventional window: lowest CONV_SEGS segments of the lower half
   assign conv_hit = !hi_half && (idx < CONV_LIM);

endmodule

// File: rtl/umb_window_sel.sv
`timescale 1ns/1ps
module umb_window_sel
   import umb_remap_pkg::*;
#(
   parameter int                                NUM_UP   = 8,
   parameter int                                NUM_UMB  = 2,
   parameter logic [NUM_UMB-1:0][SEG_SLOT_W-1:0] WIN_SEG  = {8'hE, 8'hD},
   parameter strap_pol_e                        STRAP_POL = STRAP_DIS_HIGH
) (
   input  logic [NUM_UP-1:0]  up_sel_n,
   input  logic [NUM_UMB-1:0] strap,
   output logic [NUM_UMB-1:0] win_hit
);
   localparam int IDX_W = $clog2(NUM_UP);

   for (genvar k = 0; k < NUM_UMB; k++) begin : g_win
      localparam logic [IDX_W-1:0] IDX = WIN_SEG[k][IDX_W-1:0];
      logic en;
      if (STRAP_POL == STRAP_DIS_HIGH) begin : g_pol_hi
         assign en = !strap[k];
      end else begin : g_pol_lo
         assign en = strap[k];
      end
      assign win_hit[k] = en && !up_sel_n[IDX];
   end

endmodule

// File: rtl/umb_addr_remap.sv
`timescale 1ns/1ps
module umb_addr_remap
   import umb_remap_pkg::*;
#(
   parameter int                                RAM_AW  = 19,
   parameter int                                SEG_AW  = 16,
   parameter int                                NUM_UMB = 2,
   parameter logic [NUM_UMB-1:0][SEG_SLOT_W-1:0] WIN_SEG = {8'hE, 8'hD},
   parameter logic [NUM_UMB-1:0][SEG_SLOT_W-1:0] RAM_SEG = {8'h7, 8'h6},
   parameter remap_style_e                      STYLE   = REMAP_FLIP
) (
   input  logic [RAM_AW-1:0]  bus_lo,
   input  logic [NUM_UMB-1:0] win_hit,
   output logic [RAM_AW-1:0]  ram_addr
);
   localparam int RS_W = RAM_AW - SEG_AW;

   logic [RS_W-1:0] seg_in;
   logic [RS_W-1:0] seg_out;

   assign seg_in = bus_lo[RAM_AW-1:SEG_AW];

   if (STYLE == REMAP_FLIP) begin : g_flip
      // Flip only the address lines that differ between bus and RAM segment
      logic [NUM_UMB-1:0][RS_W-1:0] terms;
      logic [RS_W-1:0]              flip;
      for (genvar k = 0; k < NUM_UMB; k++) begin : g_term
         localparam logic [RS_W-1:0] DIFF =
            WIN_SEG[k][RS_W-1:0] ^ RAM_SEG[k][RS_W-1:0];
         assign terms[k] = win_hit[k] ? DIFF : '0;
      end
      always_comb begin
         flip = '0;
         for (int k = 0; k < NUM_UMB; k++) flip = flip | terms[k];
      end
      assign seg_out = seg_in ^ flip;
   end else begin : g_replace
      // Substitute the whole segment field from the window table
      always_comb begin
         seg_out = seg_in;
         for (int k = 0; k < NUM_UMB; k++) begin
            if (win_hit[k]) seg_out = RAM_SEG[k][RS_W-1:0];
         end
      end
   end

   assign ram_addr = {seg_out, bus_lo[SEG_AW-1:0]};

endmodule

// File: rtl/umb_bus_ctrl.sv
`timescale 1ns/1ps
module umb_bus_ctrl #(
   parameter int NUM_UMB = 2
) (
   input  logic               conv_hit,
   input  logic [NUM_UMB-1:0] win_hit,
   input  logic               memr_n,
   input  logic               memw_n,
   output logic               ram_cs_n,
   output logic               xcvr_en_n,
   output logic               xcvr_dir
);
   logic strobe;
   logic sel;

   assign strobe    = !memr_n || !memw_n;
   assign sel       = (conv_hit || (|win_hit)) && strobe;
   assign ram_cs_n  = !sel;
   assign xcvr_en_n = !sel;
   assign xcvr_dir  = sel && !memr_n;

endmodule

// File: rtl/umb_remap.sv
`timescale 1ns/1ps
module umb_remap
   import umb_remap_pkg::*;
#(
   parameter int                                BUS_AW    = 20,
   parameter int                                RAM_AW    = 19,
   parameter int                                SEG_AW    = 16,
   parameter int                                CONV_SEGS = 6,
   parameter int                                NUM_UMB   = 2,
   parameter logic [NUM_UMB-1:0][SEG_SLOT_W-1:0] WIN_SEG   = {8'hE, 8'hD},
   parameter logic [NUM_UMB-1:0][SEG_SLOT_W-1:0] RAM_SEG   = {8'h7, 8'h6},
   parameter strap_pol_e                        STRAP_POL = STRAP_DIS_HIGH,
   parameter remap_style_e                      STYLE     = REMAP_FLIP
) (
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic               memr_n,
   input  logic               memw_n,
   input  logic [NUM_UMB-1:0] umb_dis,
   output logic [RAM_AW-1:0]  ram_addr,
   output logic               ram_cs_n,
   output logic               xcvr_en_n,
   output logic               xcvr_dir
);
   localparam int SEG_BITS = BUS_AW - SEG_AW;
   localparam int NUM_UP   = 1 << (SEG_BITS - 1);
   localparam int RS_W     = RAM_AW - SEG_AW;

   // Elaboration-time parameter checks
   if (RAM_AW != BUS_AW - 1) begin : g_bad_ram
      $error("umb_remap: RAM must be half the bus address space");
   end
   if (SEG_AW >= RAM_AW) begin : g_bad_seg
      $error("umb_remap: segment size must be below RAM size");
   end
   if (CONV_SEGS + NUM_UMB > (1 << RS_W)) begin : g_bad_fit
      $error("umb_remap: windows do not fit in RAM");
   end
   for (genvar k = 0; k < NUM_UMB; k++) begin : g_chk_win
      if (WIN_SEG[k][SEG_BITS-1] != 1'b1) begin : g_bad_hi
         $error("umb_remap: upper window outside upper half");
      end
      if (int'(RAM_SEG[k]) < CONV_SEGS) begin : g_bad_alias
         $error("umb_remap: window RAM segment overlaps conventional");
      end
      for (genvar j = 0; j < k; j++) begin : g_pair
         if (RAM_SEG[k] == RAM_SEG[j]) begin : g_bad_dup
            $error("umb_remap: two windows share a RAM segment");
         end
      end
   end

   logic [NUM_UP-1:0]  up_sel_n;
   logic               conv_hit;
   logic [NUM_UMB-1:0] win_hit;

   umb_seg_decoder #(
      .SEG_BITS  (SEG_BITS),
      .CONV_SEGS (CONV_SEGS)
   ) u_dec (
      .seg      (bus_addr[BUS_AW-1:SEG_AW]),
      .up_sel_n (up_sel_n),
      .conv_hit (conv_hit)
   );

   umb_window_sel #(
      .NUM_UP    (NUM_UP),
      .NUM_UMB   (NUM_UMB),
      .WIN_SEG   (WIN_SEG),
      .STRAP_POL (STRAP_POL)
   ) u_win (
      .up_sel_n (up_sel_n),
      .strap    (umb_dis),
      .win_hit  (win_hit)
   );

   umb_addr_remap #(
      .RAM_AW  (RAM_AW),
      .SEG_AW  (SEG_AW),
      .NUM_UMB (NUM_UMB),
      .WIN_SEG (WIN_SEG),
      .RAM_SEG (RAM_SEG),
      .STYLE   (STYLE)
   ) u_map (
      .bus_lo   (bus_addr[RAM_AW-1:0]),
      .win_hit  (win_hit),
      .ram_addr (ram_addr)
   );

   umb_bus_ctrl #(
      .NUM_UMB (NUM_UMB)
   ) u_ctl (
      .conv_hit  (conv_hit),
      .win_hit   (win_hit),
      .memr_n    (memr_n),
      .memw_n    (memw_n),
      .ram_cs_n  (ram_cs_n),
      .xcvr_en_n (xcvr_en_n),
      .xcvr_dir  (xcvr_dir)
   );

endmodule

// File: rtl/umb_remap_chk.sv
`timescale 1ns/1ps
module umb_remap_chk
   import umb_remap_pkg::*;
#(
   parameter int                                BUS_AW    = 20,
   parameter int                                RAM_AW    = 19,
   parameter int                                SEG_AW    = 16,
   parameter int                                CONV_SEGS = 6,
   parameter int                                NUM_UMB   = 2,
   parameter logic [NUM_UMB-1:0][SEG_SLOT_W-1:0] WIN_SEG   = {8'hE, 8'hD},
   parameter strap_pol_e                        STRAP_POL = STRAP_DIS_HIGH
) (
   input logic [BUS_AW-1:0]  bus_addr,
   input logic               memr_n,
   input logic               memw_n,
   input logic [NUM_UMB-1:0] umb_dis,
   input logic [RAM_AW-1:0]  ram_addr,
   input logic               ram_cs_n,
   input logic               xcvr_en_n,
   input logic               xcvr_dir
);
   localparam int SEG_BITS = BUS_AW - SEG_AW;

   logic [SEG_BITS-1:0] seg;
   logic                in_conv;
   logic                en_win_match;
   logic                dis_win_match;

   assign seg     = bus_addr[BUS_AW-1:SEG_AW];
   assign in_conv = (int'(seg) < CONV_SEGS);

   always_comb begin
      en_win_match  = 1'b0;
      dis_win_match = 1'b0;
      for (int k = 0; k < NUM_UMB; k++) begin
         if (seg == WIN_SEG[k][SEG_BITS-1:0]) begin
            if (umb_dis[k] == (STRAP_POL == STRAP_DIS_HIGH)) dis_win_match = 1'b1;
            else                                             en_win_match  = 1'b1;
         end
      end
   end

   always_comb begin
      if (!$isunknown({bus_addr, memr_n, memw_n, umb_dis})) begin
         // R8
         p_en_follows_cs_r8: assert (xcvr_en_n == ram_cs_n)
            else $error("enable differs from chip select");
         // R6
         p_idle_no_select_r6: assert (!(memr_n && memw_n) || ram_cs_n)
            else $error("select without strobe");
         // R7
         p_dir_on_read_only_r7: assert (!xcvr_dir || (!memr_n && !ram_cs_n))
            else $error("direction toward bus outside a selected read");
         // R5
         p_no_select_outside_r5: assert (in_conv || en_win_match || ram_cs_n)
            else $error("select in a forbidden segment");
         // R4
         p_disabled_window_r4: assert (!dis_win_match || ram_cs_n)
            else $error("disabled window selected");
         // R1
         p_conv_identity_r1: assert (!in_conv || ram_addr == bus_addr[RAM_AW-1:0])
            else $error("conventional address not identity");
         // R9
         p_offset_kept_r9: assert (ram_cs_n || ram_addr[SEG_AW-1:0] == bus_addr[SEG_AW-1:0])
            else $error("offset altered");
      end
   end

endmodule

bind umb_remap umb_remap_chk #(
   .BUS_AW    (BUS_AW),
   .RAM_AW    (RAM_AW),
   .SEG_AW    (SEG_AW),
   .CONV_SEGS (CONV_SEGS),
   .NUM_UMB   (NUM_UMB),
   .WIN_SEG   (WIN_SEG),
   .STRAP_POL (STRAP_POL)
) u_chk (
   .bus_addr  (bus_addr),
   .memr_n    (memr_n),
   .memw_n    (memw_n),
   .umb_dis   (umb_dis),
   .ram_addr  (ram_addr),
   .ram_cs_n  (ram_cs_n),
   .xcvr_en_n (xcvr_en_n),
   .xcvr_dir  (xcvr_dir)
);

// File: tb/test_umb_remap.sv
`timescale 1ns/1ps
module test_umb_remap;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] bus_addr = '0;
   logic        memr_n = 1'b1;
   logic        memw_n = 1'b1;
   logic [1:0]  umb_dis = 2'b11;
   logic [18:0] ram_addr;
   logic        ram_cs_n;
   logic        xcvr_en_n;
   logic        xcvr_dir;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   umb_remap i_umb_remap (
      .bus_addr  (bus_addr),
      .memr_n    (memr_n),
      .memw_n    (memw_n),
      .umb_dis   (umb_dis),
      .ram_addr  (ram_addr),
      .ram_cs_n  (ram_cs_n),
      .xcvr_en_n (xcvr_en_n),
      .xcvr_dir  (xcvr_dir)
   );

   // {req[3:0], addr[19:0], rd_n, wr_n, dis[1:0], exp_cs_n, exp_dir, exp_ram[18:0]}
   localparam int NV = 18;
   localparam logic [48:0] VEC [NV] = '{
      {4'd1, 20'h00000, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 19'h00000}, // R1 read low edge
      {4'd1, 20'h5FFFF, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 19'h5FFFF}, // R1 write top edge
      {4'd1, 20'h12345, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 19'h12345}, // R1
      {4'd5, 20'h60000, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 19'h60000}, // R5 just above conv
      {4'd2, 20'hD0000, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 19'h60000}, // R2
      {4'd2, 20'hDFFFF, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 19'h6FFFF}, // R2 write
      {4'd4, 20'hD1234, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 19'h51234}, // R4 D disabled
      {4'd3, 20'hE0000, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 19'h70000}, // R3
      {4'd3, 20'hEABCD, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 19'h7ABCD}, // R3 write
      {4'd4, 20'hE0000, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 19'h60000}, // R4 E disabled
      {4'd5, 20'hA0000, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 19'h20000}, // R5
      {4'd5, 20'hC8000, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 19'h48000}, // R5
      {4'd5, 20'hF0000, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 19'h70000}, // R5
      {4'd5, 20'hB0000, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 19'h30000}, // R5
      {4'd6, 20'h30000, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 19'h30000}, // R6 idle
      {4'd6, 20'hD0000, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 19'h60000}, // R6 idle in window
      {4'd7, 20'h40000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 19'h40000}, // R7 both strobes
      {4'd5, 20'h9FFFF, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 19'h1FFFF}  // R5
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [19:0] a, input logic rd_n, input logic wr_n,
                        input logic [1:0] dis);
      @(posedge clk);
      bus_addr = a;
      memr_n   = rd_n;
      memw_n   = wr_n;
      umb_dis  = dis;
      @(negedge clk);
   endtask

   // Requirement model for the sweep: returns select and RAM address
   function automatic void model(input logic [19:0] a, input logic [1:0] dis,
                                 output logic sel, output logic [18:0] ra);
      logic [3:0] s;
      s   = a[19:16];
      sel = 1'b0;
      ra  = a[18:0];
      if (s < 4'd6) begin
         sel = 1'b1;
      end else if (s == 4'hD && !dis[0]) begin
         sel = 1'b1;
         ra  = {3'h6, a[15:0]};
      end else if (s == 4'hE && !dis[1]) begin
         sel = 1'b1;
         ra  = {3'h7, a[15:0]};
      end
   endfunction

   initial begin
      // Reset / idle state, R6 R7 R8
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6", "idle cs_n", 32'(ram_cs_n), 32'd1);
      check("R8", "idle en_n", 32'(xcvr_en_n), 32'd1);
      check("R7", "idle dir", 32'(xcvr_dir), 32'd0);
      rst = 1'b0;

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [48:0] v;
         string rq;
         v = VEC[i];
         rq = $sformatf("R%0d", v[48:45]);
         apply(v[44:25], v[24], v[23], v[22:21]);
         check(rq, "cs_n", 32'(ram_cs_n), 32'(v[20]));
         check("R8", "en_n", 32'(xcvr_en_n), 32'(v[20]));
         check(rq, "dir", 32'(xcvr_dir), 32'(v[19]));
         check(rq, "ram_addr", 32'(ram_addr), 32'(v[18:0]));
      end

      // Sweep every segment under every strap setting, R1 R2 R3 R4 R5
      for (int d = 0; d < 4; d++) begin
         for (int s = 0; s < 16; s++) begin
            logic [19:0] a;
            logic        esel;
            logic [18:0] era;
            a = {4'(s), 16'(16'h1F3C ^ (s * 16'h0101))};
            model(a, 2'(d), esel, era);
            apply(a, 1'b0, 1'b1, 2'(d));
            check("R5", "sweep cs_n", 32'(ram_cs_n), 32'(!esel));
            check("R7", "sweep dir", 32'(xcvr_dir), 32'(esel));
            check("R2", "sweep ram_addr", 32'(ram_addr), 32'(era));
         end
      end

      // Uniqueness with both windows enabled, R9
      begin
         logic [7:0] used;
         int nsel;
         used = '0;
         nsel = 0;
         for (int s = 0; s < 16; s++) begin
            apply({4'(s), 16'hA5C3}, 1'b1, 1'b0, 2'b00);
            if (!ram_cs_n) begin
               nsel++;
               check("R9", "segment reused", 32'(used[ram_addr[18:16]]), 32'd0);
               check("R9", "offset", 32'(ram_addr[15:0]), 32'hA5C3);
               used[ram_addr[18:16]] = 1'b1;
            end
         end
         check("R9", "selected segments", 32'(nsel), 32'd8);
         check("R9", "RAM coverage", 32'(used), 32'hFF);
      end

      apply(20'h00000, 1'b1, 1'b1, 2'b11);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      end
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      end
      $finish;
   end

endmodule